// File: doc/BRIEF.md
# Read-Strobe Delay Window Calibrator

This block centres the read-strobe delay of a DRAM interface. On a start pulse it steps a delay tap through every setting from the lowest to the highest. At each setting it drives the tap onto the delay control of every byte lane and runs an external memory self-test. It then judges the tap by the comparison count that the self-test reports.

The block keeps the lowest and the highest passing settings and counts the passes. When the sweep ends it programs the midpoint of the two into every lane. If no setting passed, it puts back the tap that was present when calibration started.

A self-test that never reports completion is cut off by a timeout. The tap under test then counts as a failure and a sticky error flag is raised. The finished result stays on the outputs with a valid flag until the next calibration request.

Top module: `strobe_window_cal`

## Requirements
- R1: After `calStart` in idle, the block tests tap values 0 through 2**TAP_W-1 (0..63 by default) exactly once each, in ascending order. `bistRun` rises once per tap.
- R2: On every cycle, every lane slice of `laneTaps` carries the same value. Lane i occupies bits [i*TAP_W +: TAP_W]. When `bistRun` rises, that value is the tap under test.
- R3: A tap passes only when the 8-bit `bistCount` equals EXPECT_CNT (8 by default) exactly, sampled in the cycle where `bistDone` is seen high.
- R4: `bistRun` stays high until `bistDone` is sampled high, and is low on the following cycle. It stays low for at least two cycles before the next tap is tested.
- R5: The first passing tap is captured once. The last passing tap follows every later pass. `passCount` ends equal to the number of passing taps, whether or not the passes are contiguous.
- R6: If at least one tap passed, the final tap equals (first + last) / 2, truncated to TAP_W bits.
- R7: If no tap passed, the final tap equals the `priorTap` value sampled with `calStart`.
- R8: If `bistDone` does not arrive within TIMEOUT_CYC cycles of `bistRun` being high, then `bistRun` drops, that tap fails, `timeoutErr` is set until the next start, and the sweep continues.
- R9: In the cycle where `calValid` rises, all lanes and `resultTap` hold the final tap. `calValid` stays high until the next accepted `calStart`, and a `calStart` during a sweep is ignored.
- R10: After reset, `laneTaps`, `resultTap`, `passCount`, `calValid`, `bistRun` and `timeoutErr` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| calStart | input | 1 | Start pulse, accepted only while idle |
| priorTap | input | TAP_W | Tap in use before calibration, restored when no tap passes |
| bistDone | input | 1 | Self-test completion flag |
| bistCount | input | 8 | Comparison count reported by the self-test |
| bistRun | output | 1 | Self-test run request, held high while a test is outstanding |
| laneTaps | output | NUM_LANES*TAP_W | Per-lane delay tap, lane i in bits [i*TAP_W +: TAP_W] |
| resultTap | output | TAP_W | Final calibrated tap |
| passCount | output | TAP_W+1 | Number of passing taps in the last sweep |
| calValid | output | 1 | Calibration finished, result valid |
| timeoutErr | output | 1 | A self-test timed out during the last sweep |

## Verification
The bench targets several corner cases:
- A window with a failing hole inside it. A design that centred on the largest contiguous run, or one that reset its first tap on a failure, would report the wrong tap.
- Passes only at taps 0 and 63. This exposes a midpoint that overflows or drops the carry bit.
- Counts of 7, 9, 0 and 0x88. These catch a pass test that uses a threshold or compares only the low bits.
- A sweep with no passes. A design that forgot the restore would leave tap 0 or the midpoint of empty registers.
- A hung self-test and a mid-sweep start pulse. These show up as a stuck sweep, a wrong run length, or a restarted tap order.

// File: rtl/calib_pkg.sv
package calib_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_TEST,
    ST_CLOSE,
    ST_FINISH
  } calState_t;

  typedef struct packed {
    logic startSweep;
    logic applyTap;
    logic sampleResult;
    logic timedOut;
    logic stepTap;
    logic finish;
  } calStrobe_t;

endpackage

// File: rtl/cal_control.sv
module cal_control
  import calib_pkg::*;
#(
  parameter int TIMEOUT_CYC = 256
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       calStart,
  input  logic       bistDone,
  input  logic       atLastTap,
  output logic       bistRun,
  output calStrobe_t strobe
);
  localparam int TMR_W = $clog2(TIMEOUT_CYC) + 1;
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(TIMEOUT_CYC - 1);

  calState_t state, stateNext;
  logic [TMR_W-1:0] waitTimer;

  assign bistRun = (state == ST_TEST);

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (calStart) begin
          strobe.startSweep = 1'b1;
          stateNext = ST_LOAD;
        end
      end
      ST_LOAD: begin
        strobe.applyTap = 1'b1;
        stateNext = ST_TEST;
      end
      ST_TEST: begin
        if (bistDone) begin
          strobe.sampleResult = 1'b1;
          stateNext = ST_CLOSE;
        end else if (waitTimer == TMR_LAST) begin
          strobe.timedOut = 1'b1;
          stateNext = ST_CLOSE;
        end
      end
      ST_CLOSE: begin
        if (atLastTap) begin
          stateNext = ST_FINISH;
        end else begin
          strobe.stepTap = 1'b1;
          stateNext = ST_LOAD;
        end
      end
      ST_FINISH: begin
        strobe.finish = 1'b1;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      waitTimer <= '0;
    end else begin
      state <= stateNext;
      if (state != ST_TEST) waitTimer <= '0;
      else                  waitTimer <= waitTimer + 1'b1;
    end
  end
endmodule

// File: rtl/cal_datapath.sv
module cal_datapath
  import calib_pkg::*;
#(
  parameter int TAP_W      = 6,
  parameter int NUM_LANES  = 2,
  parameter int EXPECT_CNT = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  calStrobe_t                 strobe,
  input  logic [TAP_W-1:0]           priorTap,
  input  logic [7:0]                 bistCount,
  output logic                       atLastTap,
  output logic [NUM_LANES*TAP_W-1:0] laneTaps,
  output logic [TAP_W-1:0]           resultTap,
  output logic [TAP_W:0]             passCount,
  output logic                       calValid,
  output logic                       timeoutErr
);
  localparam logic [TAP_W-1:0] TAP_MAX  = {TAP_W{1'b1}};
  localparam logic [7:0]       CNT_GOOD = 8'(EXPECT_CNT);

  logic [TAP_W-1:0] savedTap, curTap, firstTap, lastTap, finalTap;
  logic [TAP_W:0]   windowSum;
  logic             seenPass, tapPasses;

  assign atLastTap = (curTap == TAP_MAX);
  assign tapPasses = (bistCount == CNT_GOOD);
  assign windowSum = {1'b0, firstTap} + {1'b0, lastTap};
  assign finalTap  = seenPass ? windowSum[TAP_W:1] : savedTap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      savedTap   <= '0;
      curTap     <= '0;
      firstTap   <= '0;
      lastTap    <= '0;
      seenPass   <= 1'b0;
      passCount  <= '0;
      resultTap  <= '0;
      calValid   <= 1'b0;
      timeoutErr <= 1'b0;
    end else begin
      if (strobe.startSweep) begin
        savedTap   <= priorTap;
        curTap     <= '0;
        firstTap   <= '0;
        lastTap    <= '0;
        seenPass   <= 1'b0;
        passCount  <= '0;
        calValid   <= 1'b0;
        timeoutErr <= 1'b0;
      end
      if (strobe.sampleResult && tapPasses) begin
        if (!seenPass) firstTap <= curTap;
        lastTap   <= curTap;
        seenPass  <= 1'b1;
        passCount <= passCount + 1'b1;
      end
      if (strobe.timedOut) timeoutErr <= 1'b1;
      if (strobe.stepTap)  curTap <= curTap + 1'b1;
      if (strobe.finish) begin
        resultTap <= finalTap;
        calValid  <= 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NUM_LANES; g++) begin : gLane
    logic [TAP_W-1:0] laneReg;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                laneReg <= '0;
      else if (strobe.applyTap) laneReg <= curTap;
      else if (strobe.finish)   laneReg <= finalTap;
    end
    assign laneTaps[g*TAP_W +: TAP_W] = laneReg;
  end
endmodule

// File: rtl/strobe_window_cal.sv
module strobe_window_cal
  import calib_pkg::*;
#(
  parameter int TAP_W       = 6,
  parameter int NUM_LANES   = 2,
  parameter int EXPECT_CNT  = 8,
  parameter int TIMEOUT_CYC = 256
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       calStart,
  input  logic [TAP_W-1:0]           priorTap,
  input  logic                       bistDone,
  input  logic [7:0]                 bistCount,
  output logic                       bistRun,
  output logic [NUM_LANES*TAP_W-1:0] laneTaps,
  output logic [TAP_W-1:0]           resultTap,
  output logic [TAP_W:0]             passCount,
  output logic                       calValid,
  output logic                       timeoutErr
);
  calStrobe_t strobe;
  logic       atLastTap;

  cal_control #(.TIMEOUT_CYC(TIMEOUT_CYC)) uCtl (
    .clk(clk), .rstN(rstN), .calStart(calStart), .bistDone(bistDone),
    .atLastTap(atLastTap), .bistRun(bistRun), .strobe(strobe)
  );

  cal_datapath #(.TAP_W(TAP_W), .NUM_LANES(NUM_LANES), .EXPECT_CNT(EXPECT_CNT)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .priorTap(priorTap),
    .bistCount(bistCount), .atLastTap(atLastTap), .laneTaps(laneTaps),
    .resultTap(resultTap), .passCount(passCount), .calValid(calValid),
    .timeoutErr(timeoutErr)
  );
endmodule

// File: rtl/strobe_window_cal_chk.sv
module strobe_window_cal_chk #(
  parameter int TAP_W     = 6,
  parameter int NUM_LANES = 2
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       calStart,
  input logic                       bistRun,
  input logic                       bistDone,
  input logic [NUM_LANES*TAP_W-1:0] laneTaps,
  input logic [TAP_W-1:0]           resultTap,
  input logic [TAP_W:0]             passCount,
  input logic                       calValid,
  input logic                       timeoutErr
);
  for (genvar g = 1; g < NUM_LANES; g++) begin : gSame
    assert_lanes_equal_R2: assert property (@(posedge clk) disable iff (!rstN)
      laneTaps[g*TAP_W +: TAP_W] == laneTaps[TAP_W-1:0]);
  end

  assert_run_drops_R4: assert property (@(posedge clk) disable iff (!rstN)
    (bistRun && bistDone) |=> !bistRun);

  assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    passCount <= (TAP_W+1)'(2**TAP_W));

  assert_result_on_lanes_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(calValid) |-> (laneTaps[TAP_W-1:0] == resultTap));

  assert_valid_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    calValid |-> !bistRun);

  assert_timeout_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(timeoutErr) && !$past(calStart)) |-> ($past(bistRun) && !$past(bistDone)));
endmodule

bind strobe_window_cal strobe_window_cal_chk #(.TAP_W(TAP_W), .NUM_LANES(NUM_LANES)) uChk (
  .clk(clk), .rstN(rstN), .calStart(calStart), .bistRun(bistRun), .bistDone(bistDone),
  .laneTaps(laneTaps), .resultTap(resultTap), .passCount(passCount),
  .calValid(calValid), .timeoutErr(timeoutErr)
);

// File: tb/sim_strobe_window_cal.sv
module sim_strobe_window_cal;
  localparam int TAP_W = 6;
  localparam int LANES = 2;
  localparam int NTAPS = 64;
  localparam int TMO   = 256;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic calStart = 1'b0;
  logic [TAP_W-1:0] priorTap = '0;
  logic bistDone = 1'b0;
  logic [7:0] bistCount = '0;
  logic bistRun;
  logic [LANES*TAP_W-1:0] laneTaps;
  logic [TAP_W-1:0] resultTap;
  logic [TAP_W:0] passCount;
  logic calValid, timeoutErr;

  always #4 clk = ~clk;

  strobe_window_cal u0 (
    .clk(clk), .rstN(rstN), .calStart(calStart), .priorTap(priorTap),
    .bistDone(bistDone), .bistCount(bistCount), .bistRun(bistRun),
    .laneTaps(laneTaps), .resultTap(resultTap), .passCount(passCount),
    .calValid(calValid), .timeoutErr(timeoutErr)
  );

  int tests = 0, fails = 0, cycles = 0;
  bit passMap[NTAPS];
  bit hangMap[NTAPS];
  int expQ[$];
  int runCyc = 0, curTap = 0, runs = 0;
  bit prevRun = 0, prevValid = 0, scenDone = 0;
  int expTap, expCnt; bit expErr;

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int latOf(int t); return (t % 3) + 1; endfunction
  function automatic logic [7:0] failCode(int t);
    case (t % 4)
      0: return 8'd7;
      1: return 8'd9;
      2: return 8'd0;
      default: return 8'h88;
    endcase
  endfunction

  // reference model and self-test stand-in, evaluated away from the rising edge
  always @(negedge clk) begin
    cycles++;
    if (rstN) begin
      for (int l = 1; l < LANES; l++)
        if (laneTaps[l*TAP_W +: TAP_W] != laneTaps[TAP_W-1:0])
          check("R2 lane match", int'(laneTaps[l*TAP_W +: TAP_W]), int'(laneTaps[TAP_W-1:0]));
      if (bistRun && !prevRun) begin
        curTap = int'(laneTaps[TAP_W-1:0]);
        runs++;
        if (expQ.size() == 0) check("R1 unexpected extra test", 1, 0);
        else check("R1 R2 tap order", curTap, expQ.pop_front());
        if (calValid) check("R9 valid during test", 1, 0);
      end
      if (!bistRun && prevRun) begin
        if (hangMap[curTap]) check("R8 timeout length", runCyc, TMO);
        else check("R4 run length", runCyc, latOf(curTap));
      end
      if (calValid && !prevValid) begin
        check("R1 all taps tested", expQ.size(), 0);
        check("R6 R7 result tap", int'(resultTap), expTap);
        check("R9 lanes hold result", int'(laneTaps[TAP_W-1:0]), expTap);
        check("R5 pass count", int'(passCount), expCnt);
        check("R8 timeout flag", int'(timeoutErr), int'(expErr));
        scenDone = 1;
      end
      prevRun = bistRun;
      prevValid = calValid;
      if (bistRun) begin
        runCyc++;
        bistDone  = !hangMap[curTap] && (runCyc >= latOf(curTap));
        bistCount = passMap[curTap] ? 8'd8 : failCode(curTap);
      end else begin
        if (!prevRun) runCyc = 0;
        bistDone = 1'b0;
        bistCount = 8'd0;
      end
      if (!bistRun && prevRun == 0) runCyc = 0;
    end
  end

  // watchdog
  initial begin
    wait (cycles >= 100000);
    fails++; tests++;
    $display("FAIL watchdog: actual %0d expected <100000", cycles);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic runScenario(input logic [TAP_W-1:0] prior, input bit poke);
    int f, l;
    f = -1; l = -1; expCnt = 0; expErr = 0;
    for (int t = 0; t < NTAPS; t++) begin
      if (hangMap[t]) expErr = 1;
      else if (passMap[t]) begin
        if (f < 0) f = t;
        l = t; expCnt++;
      end
    end
    expTap = (f < 0) ? int'(prior) : ((f + l) / 2) % NTAPS;
    for (int t = 0; t < NTAPS; t++) expQ.push_back(t);
    scenDone = 0; runs = 0;
    @(negedge clk);
    priorTap = prior; calStart = 1'b1;
    @(negedge clk);
    calStart = 1'b0;
    if (poke) begin
      repeat (100) @(negedge clk);
      priorTap = ~prior; calStart = 1'b1;
      @(negedge clk);
      calStart = 1'b0;
    end
    while (!scenDone) @(posedge clk);
    check("R1 test count", runs, NTAPS);
    repeat (5) @(negedge clk);
    check("R9 valid held", int'(calValid), 1);
    check("R9 result held", int'(resultTap), expTap);
  endtask

  task automatic clearMaps;
    for (int t = 0; t < NTAPS; t++) begin passMap[t] = 0; hangMap[t] = 0; end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R10 lanes reset", int'(laneTaps), 0);
    check("R10 valid reset", int'(calValid), 0);
    check("R10 run reset", int'(bistRun), 0);
    check("R10 err reset", int'(timeoutErr), 0);
    check("R10 count reset", int'(passCount), 0);
    check("R10 result reset", int'(resultTap), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // contiguous window 20..30, with an ignored mid-sweep start (R9)
    clearMaps();
    for (int t = 20; t <= 30; t++) passMap[t] = 1;
    runScenario(6'd12, 1);

    // no passing tap: restore prior (R7); near-miss counts exercise R3
    clearMaps();
    runScenario(6'd37, 0);

    // holes in the window: midpoint from first and last only (R5, R6)
    clearMaps();
    passMap[5] = 1; passMap[40] = 1; passMap[41] = 1;
    runScenario(6'd0, 0);

    // extremes: taps 0 and 63 pass (R6)
    clearMaps();
    passMap[0] = 1; passMap[63] = 1;
    runScenario(6'd50, 0);

    // hung self-test inside the window (R8)
    clearMaps();
    for (int t = 8; t <= 12; t++) passMap[t] = 1;
    hangMap[10] = 1;
    runScenario(6'd3, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule